// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from five sources, one external pin and four internal events (timer 0 overflow, timer 1 overflow, A/D conversion complete and time-base overflow), and turns them into vectored call requests for a processor core. Each source owns a request flag and an individual enable. A single global enable gates every source. The external pin is synchronised and passed through a programmable edge detector before it can set its flag. The pin is only considered when its direction-control input marks it as an input.

Service decisions are taken once per instruction cycle, on the rising edge of a sampling strobe. At that moment the block picks the highest-priority request that is pending and enabled, provided the global enable is set and the call stack is not full. It then issues a one-cycle call pulse carrying a fixed 8-bit vector. In the same clock edge it clears the winning flag and drops the global enable. The core restores the global enable with a dedicated re-enable pulse when it returns from the handler. Software can rewrite the flag and enable registers through a small write port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Fixed priority, highest first, follows the flag bit order: bit 0 external pin, bit 1 timer 0, bit 2 timer 1, bit 3 A/D complete, bit 4 time-base. Only the highest-priority pending and enabled source is serviced.
- R2: The vector for the source in flag bit k is 0x04 + 4*k (0x04, 0x08, 0x0C, 0x10, 0x14). `call_vec` is 0 whenever `call_req` is low.
- R3: A service decision is made only at a clock edge where `strobe` is high and was low in the previous cycle. It uses the flags as registered before that edge, and `call_req` is high in the cycle after that edge. A request set in the same cycle as the strobe rise waits for the next strobe rise.
- R4: A source is serviced only when `gie`, its enable bit and its flag are all set and `stack_full` is low. Otherwise no call is issued and no flag changes.
- R5: `call_req` is a pulse of exactly one cycle.
- R6: In the edge that raises `call_req`, the winning flag is cleared and `gie` drops to 0. Lower-priority flags stay pending.
- R7: The external edge mode `ext_mode` is encoded as 00 = external source disabled, 01 = rising edge, 10 = falling edge, 11 = both edges.
- R8: An edge on `ext_pin` is recognised only while `ext_dir_in` is 1 (pin configured as input).
- R9: `ext_pin` passes through two flip-flops. A qualifying transition sets flag bit 0 at the third rising clock edge after the pin changes, and sets it once per transition.
- R10: A flag whose enable is 0 stays pending. It is serviced at a later strobe rise once its enable is set.
- R11: The write port has two selections. `wr_sel` = 0 replaces the flags and `wr_sel` = 1 replaces the enables with `wr_data`. A set event for a flag in the same cycle as a software write or a service clear of that flag leaves the flag set.
- R12: `gie` is 0 after reset and is set only by a `gie_reenable` pulse. A re-enable pulse in the same cycle as a service leaves `gie` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_dir_in | input | 1 | 1 when the shared pin is configured as an input |
| ext_mode | input | 2 | External edge mode: 00 off, 01 rise, 10 fall, 11 both |
| int_evt | input | 4 | Internal event pulses: timer 0, timer 1, A/D done, time-base |
| strobe | input | 1 | Instruction-cycle sampling strobe |
| stack_full | input | 1 | Call stack full, inhibits service |
| gie_reenable | input | 1 | Pulse that sets the global enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = flags, 1 = enables |
| wr_data | input | 5 | Write data, one bit per source |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 8 | Vector address for the call |
| flags | output | 5 | Request flags |
| enables | output | 5 | Per-source enables |
| gie | output | 1 | Global interrupt enable |

## Verification
Two functions can land in one cycle. The first is a flag being set while it is also being cleared, either by a software write or by the service of that same source. The second is `gie_reenable` arriving in the cycle where a service clears the global enable. Directed cases pulse an internal event in the same cycle as a flag write and as the strobe rise. Random stimulus with dense event, strobe and re-enable activity produces the remaining coincidences. Each cycle the outputs are compared with a bench model that resolves every collision in favour of the set.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_NUM_SRC  = 5;
  localparam int IRQ_VEC_W    = 8;
  localparam int IRQ_VEC_BASE = 4;
  localparam int IRQ_VEC_STEP = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       pin_is_input,
  input  logic [1:0] mode,
  output logic       hit
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   synced;
  logic                   rise;
  logic                   fall;
  edge_mode_e             mode_e;

  assign synced = chain_q[SYNC_STAGES-1];
  assign rise   = synced & ~prev_q;
  assign fall   = ~synced & prev_q;
  assign mode_e = edge_mode_e'(mode);

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  always_comb begin
    hit = 1'b0;
    if (pin_is_input) begin
      unique case (mode_e)
        EDGE_OFF:  hit = 1'b0;
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] svc_clr,
  input  logic               wr_flags,
  input  logic               wr_enab,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables
);
  logic [NUM_SRC-1:0] flag_d;
  logic               flag_ce;

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      always_comb begin
        if (wr_flags) flag_d[i] = set_vec[i] | wr_data[i];
        else          flag_d[i] = set_vec[i] | (flags[i] & ~svc_clr[i]);
      end
    end
  endgenerate

  assign flag_ce = wr_flags | (|set_vec) | (|svc_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_ce) flags <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enables <= '0;
    else if (wr_enab) enables <= wr_data;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC  = 5,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [NUM_SRC-1:0] win,
  output logic [VEC_W-1:0]   vec
);
  logic [NUM_SRC:0] blocked;

  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_stage
      assign win[i]       = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
    end
  endgenerate

  assign any = blocked[NUM_SRC];

  always_comb begin
    vec = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (win[k]) vec = vec | VEC_W'(VEC_BASE + VEC_STEP * k);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = IRQ_NUM_SRC,
  parameter int VEC_W       = IRQ_VEC_W,
  parameter int VEC_BASE    = IRQ_VEC_BASE,
  parameter int VEC_STEP    = IRQ_VEC_STEP,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_pin,
  input  logic               ext_dir_in,
  input  logic [1:0]         ext_mode,
  input  logic [NUM_SRC-2:0] int_evt,
  input  logic               strobe,
  input  logic               stack_full,
  input  logic               gie_reenable,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic               call_req,
  output logic [VEC_W-1:0]   call_vec,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic               gie
);
  logic               ext_hit;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] pend;
  logic               pend_any;
  logic [NUM_SRC-1:0] pend_win;
  logic [VEC_W-1:0]   pend_vec;
  logic               strobe_q;
  logic               strobe_rise;
  logic               take;
  logic [NUM_SRC-1:0] svc_clr;
  logic               gie_d;
  logic               gie_ce;
  logic               call_d;
  logic [VEC_W-1:0]   vec_d;

  irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin          (ext_pin),
    .pin_is_input (ext_dir_in),
    .mode         (ext_mode),
    .hit          (ext_hit)
  );

  assign set_vec = {int_evt, ext_hit};

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .svc_clr  (svc_clr),
    .wr_flags (wr_en & ~wr_sel),
    .wr_enab  (wr_en & wr_sel),
    .wr_data  (wr_data),
    .flags    (flags),
    .enables  (enables)
  );

  assign pend = flags & enables;

  irq_prio_pick #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_pick (
    .req (pend),
    .any (pend_any),
    .win (pend_win),
    .vec (pend_vec)
  );

  // next-state logic
  always_comb begin
    strobe_rise = strobe & ~strobe_q;
    take        = strobe_rise & gie & ~stack_full & pend_any;
    svc_clr     = take ? pend_win : '0;
    call_d      = take;
    vec_d       = take ? pend_vec : '0;
    gie_ce      = gie_reenable | take;
    gie_d       = gie_reenable;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie <= 1'b0;
    else if (gie_ce) gie <= gie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req <= 1'b0;
      call_vec <= '0;
    end else begin
      call_req <= call_d;
      call_vec <= vec_d;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_sva.sv
module irq_vector_ctrl_sva #(
  parameter int NUM_SRC  = 5,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strobe,
  input logic               stack_full,
  input logic               gie_reenable,
  input logic               call_req,
  input logic [VEC_W-1:0]   call_vec,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] enables,
  input logic               gie
);
  logic [NUM_SRC-1:0] pend_q;
  logic               gie_q;
  logic               sf_q;
  logic               reen_q;
  logic               str_q;
  logic               str_qq;
  logic               vec_ok;
  logic               prio_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      gie_q  <= 1'b0;
      sf_q   <= 1'b0;
      reen_q <= 1'b0;
      str_q  <= 1'b0;
      str_qq <= 1'b0;
    end else begin
      pend_q <= flags & enables;
      gie_q  <= gie;
      sf_q   <= stack_full;
      reen_q <= gie_reenable;
      str_q  <= strobe;
      str_qq <= str_q;
    end
  end

  always_comb begin
    vec_ok  = 1'b0;
    prio_ok = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (call_vec == VEC_W'(VEC_BASE + VEC_STEP * i)) begin
        vec_ok = 1'b1;
        if (pend_q[i]) begin
          prio_ok = 1'b1;
          for (int j = 0; j < i; j++) begin
            if (pend_q[j]) prio_ok = 1'b0;
          end
        end
      end
    end
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  p_vec_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !call_req |-> call_vec == '0);

  p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> vec_ok);

  p_strobe_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (str_q && !str_qq));

  p_gating_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (gie_q && !sf_q));

  p_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> prio_ok);

  p_gie_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !reen_q) |-> !gie);

  p_gie_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> reen_q);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_sva #(
  .NUM_SRC  (NUM_SRC),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe       (strobe),
  .stack_full   (stack_full),
  .gie_reenable (gie_reenable),
  .call_req     (call_req),
  .call_vec     (call_vec),
  .flags        (flags),
  .enables      (enables),
  .gie          (gie)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       ext_pin;
  logic       ext_dir_in;
  logic [1:0] ext_mode;
  logic [3:0] int_evt;
  logic       strobe;
  logic       stack_full;
  logic       gie_reenable;
  logic       wr_en;
  logic       wr_sel;
  logic [4:0] wr_data;
  logic       call_req;
  logic [7:0] call_vec;
  logic [4:0] flags;
  logic [4:0] enables;
  logic       gie;

  int  n_checks;
  int  n_errors;
  bit  chk_on;
  bit  done;

  irq_vector_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_pin      (ext_pin),
    .ext_dir_in   (ext_dir_in),
    .ext_mode     (ext_mode),
    .int_evt      (int_evt),
    .strobe       (strobe),
    .stack_full   (stack_full),
    .gie_reenable (gie_reenable),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .call_req     (call_req),
    .call_vec     (call_vec),
    .flags        (flags),
    .enables      (enables),
    .gie          (gie)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- reference model ----------------
  logic       m_s1, m_s2, m_prev, m_strq, m_gie, m_call;
  logic [4:0] m_flags, m_en;
  logic [7:0] m_vec;

  function automatic int first_set(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic edge_hit(input logic dir, input logic [1:0] md,
                                    input logic cur, input logic old);
    if (!dir) return 1'b0;
    case (md)
      2'b01:   return cur & ~old;
      2'b10:   return ~cur & old;
      2'b11:   return cur ^ old;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_strq = 0; m_gie = 0; m_call = 0;
      m_flags = 0; m_en = 0; m_vec = 0;
    end else begin
      logic       hit;
      logic       take;
      logic [4:0] pend;
      logic [4:0] clr;
      logic [4:0] nf;
      int         w;
      hit  = edge_hit(ext_dir_in, ext_mode, m_s2, m_prev);
      pend = m_flags & m_en;
      w    = first_set(pend);
      take = strobe && !m_strq && m_gie && !stack_full && (w >= 0);
      clr  = take ? (5'b1 << w) : 5'b0;
      nf   = (wr_en && !wr_sel) ? wr_data : (m_flags & ~clr);
      nf   = nf | {int_evt, hit};
      if (wr_en && wr_sel) m_en = wr_data;
      if (gie_reenable) m_gie = 1'b1;
      else if (take)    m_gie = 1'b0;
      m_call  = take;
      m_vec   = take ? 8'(4 + 4 * w) : 8'h00;
      m_flags = nf;
      m_prev  = m_s2;
      m_s2    = m_s1;
      m_s1    = ext_pin;
      m_strq  = strobe;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(call_req == m_call, "R3/R5 call_req", call_req, m_call);
      check(call_vec == m_vec, "R1/R2 call_vec", call_vec, m_vec);
      check(flags == m_flags, "R6/R9/R11 flags", flags, m_flags);
      check(enables == m_en, "R11 enables", enables, m_en);
      check(gie == m_gie, "R12 gie", gie, m_gie);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [4:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 0;
  endtask

  task automatic reenable();
    gie_reenable = 1;
    step(1);
    gie_reenable = 0;
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    int_evt = e;
    step(1);
    int_evt = 0;
  endtask

  task automatic fire_strobe(output logic got, output logic [7:0] v);
    strobe = 1;
    step(1);
    got = call_req; v = call_vec;
    strobe = 0;
    step(1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic       got;
    logic [7:0] v;
    void'($urandom(32'd4242));
    n_checks = 0; n_errors = 0; chk_on = 0; done = 0;
    rst_n = 0; ext_pin = 0; ext_dir_in = 1; ext_mode = 2'b00; int_evt = 0;
    strobe = 0; stack_full = 0; gie_reenable = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    step(4);
    rst_n = 1;
    step(1);
    chk_on = 1;
    check(call_req == 0 && call_vec == 0, "R2 reset call", {call_req, call_vec}, 0);
    check(gie == 0, "R12 reset gie", gie, 0);

    // R1 priority with several pending, external pin rising (R7 mode 01)
    write_reg(1'b1, 5'b11111);
    reenable();
    ext_mode = 2'b01;
    ext_pin = 1;
    int_evt = 4'b1010;
    step(1);
    int_evt = 0;
    step(2);
    check(flags == 5'b10101, "R9 flags after pin rise", flags, 5'b10101);
    fire_strobe(got, v);
    check(got && v == 8'h04, "R1 external wins", v, 8'h04);
    check(flags == 5'b10100 && gie == 0, "R6 winner cleared gie low", {gie, flags}, 5'b10100);
    fire_strobe(got, v);
    check(!got, "R4 no call with gie low", got, 0);
    reenable();
    fire_strobe(got, v);
    check(got && v == 8'h0C, "R1 timer1 next", v, 8'h0C);

    // R4 stack full inhibits
    reenable();
    stack_full = 1;
    fire_strobe(got, v);
    check(!got && flags == 5'b10000, "R4 stack full", {got, flags}, 5'b10000);
    stack_full = 0;

    // R11 set beats software clear
    int_evt = 4'b0100;
    wr_en = 1; wr_sel = 0; wr_data = 5'b00000;
    step(1);
    int_evt = 0; wr_en = 0;
    check(flags == 5'b01000, "R11 set wins over write", flags, 5'b01000);

    // R10 pending while disabled
    write_reg(1'b1, 5'b00000);
    fire_strobe(got, v);
    check(!got && flags == 5'b01000, "R10 held while disabled", {got, flags}, 5'b01000);
    write_reg(1'b1, 5'b01000);
    fire_strobe(got, v);
    check(got && v == 8'h10, "R10 taken once enabled", v, 8'h10);

    // R7 / R8 edge modes and direction
    write_reg(1'b0, 5'b00000);
    ext_mode = 2'b00; ext_pin = 0; step(4);
    check(flags[0] == 0, "R7 mode off ignores edge", flags[0], 0);
    ext_mode = 2'b11; ext_dir_in = 0; ext_pin = 1; step(4);
    check(flags[0] == 0, "R8 output pin ignored", flags[0], 0);
    ext_dir_in = 1; ext_mode = 2'b10; ext_pin = 0; step(2);
    check(flags[0] == 0, "R9 not yet at second edge", flags[0], 0);
    step(1);
    check(flags[0] == 1, "R7 falling edge sets", flags[0], 1);
    write_reg(1'b0, 5'b00000);
    step(3);
    check(flags[0] == 0, "R9 single set per transition", flags[0], 0);

    // R3 request set in the strobe-rise cycle waits for next strobe
    write_reg(1'b1, 5'b11111);
    reenable();
    int_evt = 4'b0001;
    strobe = 1;
    step(1);
    int_evt = 0;
    check(!call_req, "R3 late request not taken", call_req, 0);
    strobe = 0;
    step(1);
    fire_strobe(got, v);
    check(got && v == 8'h08, "R3 taken on next strobe", v, 8'h08);

    // R12 reenable coinciding with service
    write_reg(1'b0, 5'b00010);
    reenable();
    strobe = 1; gie_reenable = 1;
    step(1);
    strobe = 0; gie_reenable = 0;
    check(call_req && gie, "R12 reenable beats service clear", {call_req, gie}, 2'b11);
    step(1);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      ext_pin      = ($urandom % 6 == 0) ? ~ext_pin : ext_pin;
      if ($urandom % 50 == 0) ext_mode = 2'($urandom);
      ext_dir_in   = ($urandom % 10 != 0);
      int_evt      = 4'($urandom) & 4'($urandom) & 4'($urandom);
      strobe       = ($urandom % 3 == 0);
      stack_full   = ($urandom % 8 == 0);
      gie_reenable = ($urandom % 5 == 0);
      wr_en        = ($urandom % 12 == 0);
      wr_sel       = ($urandom % 3 == 0);
      wr_data      = 5'($urandom);
      step(1);
    end
    wr_en = 0; int_evt = 0; strobe = 0; gie_reenable = 0;
    step(2);
    report();
  end
endmodule